// File: doc/BRIEF.md
# Indirect Configuration Address/Data Bridge

This unit sits between a processor bus and a configuration-space fabric. Software programs a 32-bit configuration address register, then reads or writes a data window; each window access becomes one configuration request on a downstream valid/ready port. A read waits for a response and returns its data to the processor.

The top bit of the address register gates all downstream traffic. While it is clear, window writes are absorbed and window reads return all-ones sized to the access. Sub-word window accesses fold the low two window-address bits into the downstream address, except for full-word writes, which use the register value as written. A build-time parameter selects a big-endian host, in which halfword and word data are byte-reversed on both paths.

The processor holds a request until it sees the single-cycle acknowledge. Exactly one transaction is in flight at any time.

Top module: `cfg_window_bridge`

## Requirements
- R1: After a synchronous active-low reset, the address register reads 0, `dn_valid` and `bus_ack` are low, so the gate is off.
- R2: With `bus_addr[2]`=0 the address register is accessed. `bus_size` 0=byte writes lane `bus_addr[1:0]` from `wdata[7:0]`, 1=halfword writes lanes selected by `bus_addr[1]` from `wdata[15:0]`, 2 or 3=word writes all 32 bits. Reads return the full register and are acknowledged without downstream traffic.
- R3: A downstream request (`dn_valid`) is raised only for a data-window access (`bus_addr[2]`=1) while address register bit 31 is set, and exactly once per such access.
- R4: A data-window write while bit 31 is clear is acknowledged with no downstream request.
- R5: A data-window read while bit 31 is clear returns 0x000000FF (byte), 0x0000FFFF (halfword) or 0xFFFFFFFF (word).
- R6: For window reads of every size and for byte and halfword window writes, `dn_addr` equals the address register ORed with `bus_addr[1:0]`.
- R7: A word window write uses the address register unchanged as `dn_addr`.
- R8: `dn_size` is 1, 2 or 4 for byte, halfword and word accesses, and `dn_we` equals the processor access direction.
- R9: On a little-endian build, `dn_wdata` is the processor write data masked to the access size.
- R10: A window read returns the response data masked to the access size and zero-extended; on a big-endian build, halfword and word results are byte-reversed within their size, byte results never.
- R11: A window read is not acknowledged before `rsp_valid`; while `dn_valid` waits for `dn_ready` its fields hold; `bus_ack` lasts one cycle.
- R12: On a big-endian build, halfword and word write data are byte-reversed within their size before being sent; byte data is sent unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_req | input | 1 | Processor access request, held until acknowledged |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Bit 2 selects window (1) or address register (0); bits 1:0 byte offset |
| bus_size | input | 2 | 0 byte, 1 halfword, 2/3 word |
| bus_wdata | input | 32 | Write data, low-aligned |
| bus_ack | output | 1 | One-cycle completion strobe |
| bus_rdata | output | 32 | Read data, valid with `bus_ack` |
| dn_valid | output | 1 | Downstream request valid |
| dn_ready | input | 1 | Downstream accepts request |
| dn_we | output | 1 | Request direction |
| dn_addr | output | 32 | Composed configuration address |
| dn_size | output | 3 | Access size in bytes |
| dn_wdata | output | 32 | Request write data |
| rsp_valid | input | 1 | Read response valid |
| rsp_data | input | 32 | Read response data, low-aligned |

## Verification
The hardest situation to reach is a window read that meets both downstream back-pressure and a delayed response right after the gate bit has been toggled by a sub-word write to the address register. The bench gets there by random mixes of byte-lane writes to the address register and window accesses, with `dn_ready` dropped one cycle in three and response delays of zero to three cycles. A little-endian and a big-endian instance run side by side on the same stimulus, so each access checks both data orderings.

// File: rtl/cfgw_pkg.sv
`timescale 1ns/1ps
// Shared types and helpers for the configuration window bridge.
// Assumes a 32-bit configuration data path split into four byte lanes.
package cfgw_pkg;
    localparam int unsigned CFG_DW     = 32;
    localparam int unsigned CFG_EN_BIT = 31;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'd0,
        SZ_HALF = 2'd1,
        SZ_WORD = 2'd2
    } acc_size_e;

    // Map the raw bus size code onto the enum; code 3 counts as word.
    function automatic acc_size_e norm_size(input logic [1:0] raw);
        case (raw)
            2'd0:    return SZ_BYTE;
            2'd1:    return SZ_HALF;
            default: return SZ_WORD;
        endcase
    endfunction

    // Keep only the bytes that belong to an access of the given size.
    function automatic logic [CFG_DW-1:0] size_mask(input acc_size_e s,
                                                    input logic [CFG_DW-1:0] d);
        case (s)
            SZ_BYTE: return {{(CFG_DW-8){1'b0}}, d[7:0]};
            SZ_HALF: return {{(CFG_DW-16){1'b0}}, d[15:0]};
            default: return d;
        endcase
    endfunction

    // Reverse byte order within the access size; bytes pass unchanged.
    function automatic logic [CFG_DW-1:0] size_swap(input acc_size_e s,
                                                    input logic [CFG_DW-1:0] d);
        case (s)
            SZ_BYTE: return d;
            SZ_HALF: return {{(CFG_DW-16){1'b0}}, d[7:0], d[15:8]};
            default: return {d[7:0], d[15:8], d[23:16], d[31:24]};
        endcase
    endfunction

    // Byte count reported downstream for each size.
    function automatic logic [2:0] size_bytes(input acc_size_e s);
        case (s)
            SZ_BYTE: return 3'd1;
            SZ_HALF: return 3'd2;
            default: return 3'd4;
        endcase
    endfunction
endpackage

// File: rtl/cfgw_lane_fmt.sv
`timescale 1ns/1ps
// Data formatter: masks a value to the access size and, on a big-endian
// build, reverses its bytes within that size. Purely combinational.
// Assumes data is low-aligned on both sides.
module cfgw_lane_fmt
    import cfgw_pkg::*;
#(
    parameter bit BIG_ENDIAN = 1'b0
) (
    input  acc_size_e          size_i,
    input  logic [CFG_DW-1:0]  data_i,
    output logic [CFG_DW-1:0]  data_o
);
    logic [CFG_DW-1:0] masked;

    // Drop bytes outside the access.
    assign masked = size_mask(size_i, data_i);

    generate
        if (BIG_ENDIAN) begin : g_swap
            // Big-endian host: reorder bytes within the access.
            assign data_o = size_swap(size_i, masked);
        end else begin : g_pass
            // Little-endian host: order is already right.
            assign data_o = masked;
        end
    endgenerate
endmodule

// File: rtl/cfgw_addr_reg.sv
`timescale 1ns/1ps
// Configuration address register with byte-lane writes.
// Byte writes hit one lane, halfword writes the lane pair chosen by off_i[1],
// word writes all lanes. Write data arrives low-aligned and is replicated.
// Assumes wr_en_i is a single-cycle strobe from the controller.
module cfgw_addr_reg
    import cfgw_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en_i,
    input  logic [1:0]         off_i,
    input  acc_size_e          size_i,
    input  logic [CFG_DW-1:0]  wdata_i,
    output logic [CFG_DW-1:0]  cfg_o
);
    localparam int unsigned LANES = CFG_DW / 8;

    logic [CFG_DW-1:0] cfg_q;

    generate
        for (genvar i = 0; i < LANES; i++) begin : g_lane
            logic       hit;
            logic [7:0] src;

            // Decide whether this lane is written by the current access.
            always_comb begin
                case (size_i)
                    SZ_BYTE: hit = (off_i == 2'(i));
                    SZ_HALF: hit = (off_i[1] == 1'((i / 2) % 2));
                    default: hit = 1'b1;
                endcase
            end

            // Pick the byte of the low-aligned write data feeding this lane.
            always_comb begin
                case (size_i)
                    SZ_BYTE: src = wdata_i[7:0];
                    SZ_HALF: src = wdata_i[8*(i%2) +: 8];
                    default: src = wdata_i[8*i +: 8];
                endcase
            end

            // Lane storage, cleared by reset.
            always_ff @(posedge clk) begin
                if (!rst_n)
                    cfg_q[8*i +: 8] <= 8'h00;
                else if (wr_en_i && hit)
                    cfg_q[8*i +: 8] <= src;
            end
        end
    endgenerate

    assign cfg_o = cfg_q;

    // R1
    addr_reg_reset_chk: assert property (@(posedge clk) !rst_n |=> cfg_q == '0);

    // R2
    addr_reg_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_i && size_i == SZ_WORD) |=> cfg_q == $past(wdata_i));
endmodule

// File: rtl/cfgw_ctrl.sv
`timescale 1ns/1ps
// Access sequencer: accepts one processor access at a time, serves the
// address register locally, absorbs or answers gated window accesses, and
// runs a downstream request (plus response wait for reads) when the gate
// bit is set. Assumes the requester holds bus_req until bus_ack and that a
// response never arrives in the same cycle as its request handshake.
module cfgw_ctrl
    import cfgw_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               bus_req,
    input  logic               bus_we,
    input  logic               win_sel,
    input  logic [1:0]         off_i,
    input  acc_size_e          size_i,
    input  logic [CFG_DW-1:0]  wdata_fmt_i,
    input  logic [CFG_DW-1:0]  cfg_i,
    input  logic [CFG_DW-1:0]  rsp_fmt_i,
    input  logic               rsp_valid,
    input  logic               dn_ready,
    output logic               cfg_wr_en,
    output acc_size_e          cur_size_o,
    output logic               bus_ack,
    output logic [CFG_DW-1:0]  bus_rdata,
    output logic               dn_valid,
    output logic               dn_we,
    output logic [CFG_DW-1:0]  dn_addr,
    output logic [2:0]         dn_size,
    output logic [CFG_DW-1:0]  dn_wdata
);
    typedef enum logic [1:0] {ST_IDLE, ST_ISSUE, ST_WAIT, ST_DONE} st_e;

    st_e               st_q;
    acc_size_e         size_q;
    logic              we_q;
    logic [CFG_DW-1:0] addr_q;
    logic [CFG_DW-1:0] wdata_q;
    logic [CFG_DW-1:0] rdata_q;
    logic              accept;
    logic              gate_on;

    // An access is taken only from the idle state.
    assign accept    = (st_q == ST_IDLE) && bus_req;
    assign gate_on   = cfg_i[CFG_EN_BIT];
    // Address register write strobe.
    assign cfg_wr_en = accept && !win_sel && bus_we;

    // Sequencer state and per-access latches.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q    <= ST_IDLE;
            size_q  <= SZ_WORD;
            we_q    <= 1'b0;
            addr_q  <= '0;
            wdata_q <= '0;
            rdata_q <= '0;
        end else begin
            case (st_q)
                ST_IDLE: begin
                    if (bus_req) begin
                        size_q <= size_i;
                        we_q   <= bus_we;
                        if (!win_sel) begin
                            rdata_q <= bus_we ? '0 : cfg_i;
                            st_q    <= ST_DONE;
                        end else if (!gate_on) begin
                            rdata_q <= bus_we ? '0 : size_mask(size_i, '1);
                            st_q    <= ST_DONE;
                        end else begin
                            addr_q  <= (bus_we && size_i == SZ_WORD)
                                       ? cfg_i
                                       : (cfg_i | {{(CFG_DW-2){1'b0}}, off_i});
                            wdata_q <= bus_we ? wdata_fmt_i : '0;
                            rdata_q <= '0;
                            st_q    <= ST_ISSUE;
                        end
                    end
                end
                ST_ISSUE: begin
                    if (dn_ready)
                        st_q <= we_q ? ST_DONE : ST_WAIT;
                end
                ST_WAIT: begin
                    if (rsp_valid) begin
                        rdata_q <= rsp_fmt_i;
                        st_q    <= ST_DONE;
                    end
                end
                default: st_q <= ST_IDLE;
            endcase
        end
    end

    assign cur_size_o = size_q;
    assign bus_ack    = (st_q == ST_DONE);
    assign bus_rdata  = rdata_q;
    assign dn_valid   = (st_q == ST_ISSUE);
    assign dn_we      = we_q;
    assign dn_addr    = addr_q;
    assign dn_size    = size_bytes(size_q);
    assign dn_wdata   = wdata_q;

    // R3
    dn_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dn_valid |-> cfg_i[CFG_EN_BIT]);

    // R4
    gated_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && win_sel && !gate_on) |=> (bus_ack && !dn_valid));

    // R8
    dn_size_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dn_valid |-> $countones(dn_size) == 1);

    // R11
    dn_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (dn_valid && !dn_ready) |=> (dn_valid && $stable(dn_addr) && $stable(dn_wdata)
                                     && $stable(dn_size) && $stable(dn_we)));

    // R11
    ack_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bus_ack |=> !bus_ack);

    // R11
    no_overlap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(dn_valid && bus_ack));
endmodule

// File: rtl/cfg_window_bridge.sv
`timescale 1ns/1ps
// Indirect configuration address/data bridge, top level.
// Decodes the processor access into the address register or the data
// window, formats write and read data for the host byte order, and drives
// a single-outstanding downstream request port.
// Assumes bus_addr bit WIN_BIT selects the window and bits 1:0 are the byte
// offset; other address bits are not decoded.
module cfg_window_bridge
    import cfgw_pkg::*;
#(
    parameter int unsigned ADDR_W     = 4,
    parameter int unsigned WIN_BIT    = 2,
    parameter bit          BIG_ENDIAN = 1'b0
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               bus_req,
    input  logic               bus_we,
    input  logic [ADDR_W-1:0]  bus_addr,
    input  logic [1:0]         bus_size,
    input  logic [31:0]        bus_wdata,
    output logic               bus_ack,
    output logic [31:0]        bus_rdata,
    output logic               dn_valid,
    input  logic               dn_ready,
    output logic               dn_we,
    output logic [31:0]        dn_addr,
    output logic [2:0]         dn_size,
    output logic [31:0]        dn_wdata,
    input  logic               rsp_valid,
    input  logic [31:0]        rsp_data
);
    acc_size_e         req_size;
    acc_size_e         cur_size;
    logic              win_sel;
    logic [1:0]        off;
    logic              cfg_wr_en;
    logic [CFG_DW-1:0] cfg_q;
    logic [CFG_DW-1:0] wdata_fmt;
    logic [CFG_DW-1:0] rsp_fmt;

    // Address and size decode of the processor access.
    assign req_size = norm_size(bus_size);
    assign win_sel  = bus_addr[WIN_BIT];
    assign off      = bus_addr[1:0];

    cfgw_addr_reg u_addr_reg (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en_i (cfg_wr_en),
        .off_i   (off),
        .size_i  (req_size),
        .wdata_i (bus_wdata),
        .cfg_o   (cfg_q)
    );

    cfgw_lane_fmt #(.BIG_ENDIAN(BIG_ENDIAN)) u_wr_fmt (
        .size_i (req_size),
        .data_i (bus_wdata),
        .data_o (wdata_fmt)
    );

    cfgw_lane_fmt #(.BIG_ENDIAN(BIG_ENDIAN)) u_rd_fmt (
        .size_i (cur_size),
        .data_i (rsp_data),
        .data_o (rsp_fmt)
    );

    cfgw_ctrl u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .bus_req     (bus_req),
        .bus_we      (bus_we),
        .win_sel     (win_sel),
        .off_i       (off),
        .size_i      (req_size),
        .wdata_fmt_i (wdata_fmt),
        .cfg_i       (cfg_q),
        .rsp_fmt_i   (rsp_fmt),
        .rsp_valid   (rsp_valid),
        .dn_ready    (dn_ready),
        .cfg_wr_en   (cfg_wr_en),
        .cur_size_o  (cur_size),
        .bus_ack     (bus_ack),
        .bus_rdata   (bus_rdata),
        .dn_valid    (dn_valid),
        .dn_we       (dn_we),
        .dn_addr     (dn_addr),
        .dn_size     (dn_size),
        .dn_wdata    (dn_wdata)
    );
endmodule

// File: tb/cfg_window_bridge_tb.sv
`timescale 1ns/1ps
module cfg_window_bridge_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_req = 1'b0;
    logic        bus_we = 1'b0;
    logic [3:0]  bus_addr = '0;
    logic [1:0]  bus_size = '0;
    logic [31:0] bus_wdata = '0;
    logic        dn_ready = 1'b0;
    logic        rsp_valid = 1'b0;
    logic [31:0] rsp_data = '0;

    logic        ack_le, ack_be, dv_le, dv_be, we_le, we_be;
    logic [31:0] rd_le, rd_be, da_le, da_be, dw_le, dw_be;
    logic [2:0]  ds_le, ds_be;

    int n_chk = 0;
    int n_bad = 0;
    logic [31:0] cfg_m = '0;
    bit finished = 1'b0;

    always #10 clk = ~clk;

    cfg_window_bridge #(.BIG_ENDIAN(1'b0)) u_dut (
        .clk(clk), .rst_n(rst_n), .bus_req(bus_req), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_size(bus_size), .bus_wdata(bus_wdata),
        .bus_ack(ack_le), .bus_rdata(rd_le), .dn_valid(dv_le), .dn_ready(dn_ready),
        .dn_we(we_le), .dn_addr(da_le), .dn_size(ds_le), .dn_wdata(dw_le),
        .rsp_valid(rsp_valid), .rsp_data(rsp_data));

    cfg_window_bridge #(.BIG_ENDIAN(1'b1)) u_dut_be (
        .clk(clk), .rst_n(rst_n), .bus_req(bus_req), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_size(bus_size), .bus_wdata(bus_wdata),
        .bus_ack(ack_be), .bus_rdata(rd_be), .dn_valid(dv_be), .dn_ready(dn_ready),
        .dn_we(we_be), .dn_addr(da_be), .dn_size(ds_be), .dn_wdata(dw_be),
        .rsp_valid(rsp_valid), .rsp_data(rsp_data));

    function automatic logic [31:0] exp_mask(input logic [1:0] s, input logic [31:0] d);
        if (s == 2'd0) return d & 32'h0000_00FF;
        if (s == 2'd1) return d & 32'h0000_FFFF;
        return d;
    endfunction

    function automatic logic [31:0] exp_swap(input logic [1:0] s, input logic [31:0] d);
        if (s == 2'd0) return d;
        if (s == 2'd1) return {16'h0, d[7:0], d[15:8]};
        return {d[7:0], d[15:8], d[23:16], d[31:24]};
    endfunction

    function automatic logic [2:0] exp_bytes(input logic [1:0] s);
        if (s == 2'd0) return 3'd1;
        if (s == 2'd1) return 3'd2;
        return 3'd4;
    endfunction

    task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    // One processor access with a downstream model; caller is at a negedge.
    task automatic access(input bit win, input bit we, input logic [1:0] off,
                          input logic [1:0] sz, input logic [31:0] wd);
        bit          en, issue, pend, given, done;
        int          cd, hs;
        logic [31:0] exp_addr, rv, cfg_before;
        en         = cfg_m[31];
        issue      = win && en;
        cfg_before = cfg_m;
        exp_addr   = (we && sz >= 2'd2) ? cfg_m : (cfg_m | {30'h0, off});
        pend = 0; given = 0; done = 0; cd = 0; hs = 0; rv = '0;
        bus_addr  = {1'b0, win, off};
        bus_we    = we;
        bus_size  = sz;
        bus_wdata = wd;
        bus_req   = 1'b1;
        for (int i = 0; i < 300; i++) begin
            @(negedge clk);
            if (ack_le) begin done = 1; break; end
            rsp_valid = 1'b0;
            if (pend) begin
                if (cd == 0) begin
                    rsp_valid = 1'b1; rsp_data = rv; pend = 0; given = 1;
                end else cd--;
            end
            dn_ready = ($urandom % 3) != 0;
            if ((dv_le || dv_be) && dn_ready) begin
                hs++;
                chk(dv_le && dv_be, "R11 both instances issue together", {31'h0, dv_be}, 32'h1);
                if (we && sz >= 2'd2)
                    chk(da_le == exp_addr && da_be == exp_addr, "R7 word write address", da_le, exp_addr);
                else
                    chk(da_le == exp_addr && da_be == exp_addr, "R6 merged address", da_le, exp_addr);
                chk(ds_le == exp_bytes(sz) && ds_be == exp_bytes(sz) && we_le == we && we_be == we,
                    "R8 size and direction", {28'h0, we_le, ds_le}, {28'h0, we, exp_bytes(sz)});
                if (we) begin
                    chk(dw_le == exp_mask(sz, wd), "R9 LE write data", dw_le, exp_mask(sz, wd));
                    chk(dw_be == exp_swap(sz, exp_mask(sz, wd)), "R12 BE write data", dw_be,
                        exp_swap(sz, exp_mask(sz, wd)));
                end else begin
                    pend = 1; cd = $urandom % 4; rv = $urandom;
                end
            end
        end
        chk(done, "R11 access completes", {31'h0, done}, 32'h1);
        chk(ack_be == ack_le, "R11 ack timing matches", {31'h0, ack_be}, {31'h0, ack_le});
        if (issue) chk(hs == 1, "R3 one request per gated-on access", hs, 1);
        else if (win) chk(hs == 0, "R4 gated-off access sends nothing", hs, 0);
        else chk(hs == 0, "R2 address register stays local", hs, 0);
        if (!we) begin
            if (!win) chk(rd_le == cfg_before && rd_be == cfg_before, "R2 address register read", rd_le, cfg_before);
            else if (!en) chk(rd_le == exp_mask(sz, 32'hFFFF_FFFF) && rd_be == exp_mask(sz, 32'hFFFF_FFFF),
                              "R5 all-ones read", rd_le, exp_mask(sz, 32'hFFFF_FFFF));
            else begin
                chk(given, "R11 read waits for response", {31'h0, given}, 32'h1);
                chk(rd_le == exp_mask(sz, rv), "R10 LE read data", rd_le, exp_mask(sz, rv));
                chk(rd_be == exp_swap(sz, exp_mask(sz, rv)), "R10 BE read data", rd_be,
                    exp_swap(sz, exp_mask(sz, rv)));
            end
        end
        if (!win && we) begin
            case (sz)
                2'd0:    cfg_m[8*off +: 8] = wd[7:0];
                2'd1:    cfg_m[16*off[1] +: 16] = wd[15:0];
                default: cfg_m = wd;
            endcase
        end
        bus_req = 1'b0; rsp_valid = 1'b0; dn_ready = 1'b0;
    endtask

    initial begin
        void'($urandom(32'h1234_5678));
        repeat (4) @(negedge clk);
        chk(!dv_le && !ack_le && !dv_be && !ack_be, "R1 quiet in reset", {30'h0, dv_le, ack_le}, 32'h0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!dv_le && !ack_le, "R1 quiet after reset", {30'h0, dv_le, ack_le}, 32'h0);
        access(0, 0, 2'd0, 2'd2, '0);                 // R1 register reads zero
        access(1, 0, 2'd0, 2'd2, '0);                 // R5 word
        access(1, 0, 2'd2, 2'd1, '0);                 // R5 half
        access(1, 0, 2'd3, 2'd0, '0);                 // R5 byte
        access(1, 1, 2'd1, 2'd0, 32'hA5);             // R4 dropped write
        access(0, 1, 2'd0, 2'd2, 32'h8000_0A40);      // R2 word write, gate on
        access(1, 0, 2'd3, 2'd0, '0);                 // R6 byte read offset 3
        access(1, 1, 2'd2, 2'd1, 32'hDEAD_BEEF);      // R6 R12 half write
        access(1, 1, 2'd2, 2'd2, 32'h0102_0304);      // R7 R9 word write, no merge
        access(1, 0, 2'd1, 2'd2, '0);                 // R10 word read
        access(1, 1, 2'd3, 2'd0, 32'h0000_0077);      // R12 byte unswapped
        access(0, 1, 2'd3, 2'd0, 32'h0000_0000);      // R2 byte lane clears gate
        access(0, 0, 2'd0, 2'd2, '0);                 // R2 read back
        access(1, 0, 2'd0, 2'd1, '0);                 // R5 after gate cleared
        access(0, 1, 2'd2, 2'd1, 32'h0000_8000);      // R2 half lane sets gate
        access(1, 0, 2'd2, 2'd1, '0);                 // R10 half read
        for (int k = 0; k < 400; k++) begin
            bit          win, we;
            logic [31:0] wd;
            win = ($urandom % 4) != 0;
            we  = $urandom % 2;
            wd  = $urandom;
            if (!win && we && ($urandom % 10) < 7) wd[31] = 1'b1;
            access(win, we, 2'($urandom % 4), 2'($urandom % 4), wd);
        end
        finished = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog act=%h exp=%h", 32'h0, 32'h1);
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end
endmodule